// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesizer with Shared Dual-Port Sine Table

This block is a free-running direct digital synthesis engine. A 32-bit phase accumulator adds a programmable tuning word on every enabled clock. The output frequency is therefore the clock rate times the tuning word divided by 2^32. At a 40 MHz clock, one step of the tuning word is worth roughly 9.3 mHz. The upper phase bits address a single sine table of 1024 signed 16-bit entries. The table has two synchronous read ports, and both are read on every cycle.

A mode input decides what the two read ports do. In quadrature mode, one port reads the sine entry and the other reads the entry a quarter turn ahead. The block then produces an uninterpolated sine and cosine at the same frequency. In interpolation mode, the two ports fetch neighbouring entries, and the sine is refined linearly using twelve fractional phase bits. In that mode the cosine is not produced. The two uses share the same ports, so the block never delivers an interpolated sine together with a cosine.

All arithmetic is fixed point, and the block produces one sample per cycle. A sample leaves the block three clocks after the phase it was computed from. A valid flag marks the samples that came from enabled cycles, and a second flag marks cosine samples that are real.

Top module: `qdds_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `cos_valid` are 0, and `sin_out` and `cos_out` are 0. Reset also clears the phase accumulator to zero.
- R2: On each clock edge with `enable` high, the phase advances by `tune_word` modulo 2^32. A tuning word of 0xFFC0_0000 steps the phase backwards by one table entry per cycle.
- R3: Outputs lag the phase by three clock edges. After `enable` rises, `out_valid` is 0 after the first and second edges and 1 after the third.
- R4: The first valid sample after reset, in quadrature mode, has `sin_out` = 0 and `cos_out` = 32767.
- R5: Table entry k equals round(32767 * sin(2*pi*k/1024)), with halves rounded away from zero. The table index n is phase bits [31:22].
- R6: In quadrature mode (`mode_interp` = 0), `cos_out` is table entry (n + 256) mod 1024 and `cos_valid` equals `out_valid`.
- R7: In interpolation mode (`mode_interp` = 1), `sin_out` = y0 + floor(((y1 - y0) * f) / 4096). Here y0 is entry n, y1 is entry (n + 1) mod 1024 (so 1023 is followed by 0), and f is phase bits [21:10].
- R8: In interpolation mode, `cos_out` is 0 and `cos_valid` is 0, even when `out_valid` is 1.
- R9: A change of `tune_word` applies from the next accumulator update. The phase is not reset, so the output stays phase continuous.
- R10: With `enable` low, the phase holds. `out_valid` falls three edges after `enable` falls, and while it is 0 both outputs are 0. When `enable` returns, the outputs resume from the held phase.
- R11: In quadrature mode, `sin_out` is table entry n whatever the fractional phase bits are. The mode in effect is the one sampled together with that phase, so every sample is consistent when the mode changes mid-stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Advances the phase and marks new samples valid |
| tune_word | input | 32 | Phase increment per enabled cycle |
| mode_interp | input | 1 | 0 = sine plus cosine, 1 = interpolated sine only |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample, 0 when not produced |
| out_valid | output | 1 | Sample on the outputs came from an enabled cycle |
| cos_valid | output | 1 | `cos_out` carries a real cosine sample |

## Verification
The assertions check the following on every cycle:
- the accumulator step, and that the phase holds when the block is disabled;
- the three-edge relation between `enable` and `out_valid`;
- the zero outputs during invalid cycles;
- the suppression of the cosine in interpolation mode;
- that quadrature pairs lie near the full-scale circle.

The exact sample values can only be shown by the bench's scenarios. These include the table contents, the interpolation arithmetic and its wrap from entry 1023 to 0, the quarter-turn cosine offset, and the first sample after reset. The bench also shows phase continuity across tuning-word changes, resumption after a pause, and per-sample mode consistency during mode toggling.

// File: rtl/qdds_pkg.sv
package qdds_pkg;

    localparam int PHASE_BITS = 32;
    localparam int INDEX_BITS = 10;
    localparam int FRAC_BITS  = 12;
    localparam int SAMPLE_BITS = 16;

    typedef enum logic {
        MODE_QUAD   = 1'b0,
        MODE_INTERP = 1'b1
    } qdds_mode_e;

endpackage

// File: rtl/qdds_phase_acc.sv
module qdds_phase_acc #(
    parameter int PHASE_W = qdds_pkg::PHASE_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } acc_state_t;

    acc_state_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (en) begin
            acc_d.phase = acc_q.phase + step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign phase = acc_q.phase;
endmodule

// File: rtl/qdds_addr_gen.sv
module qdds_addr_gen #(
    parameter int ADDR_W = qdds_pkg::INDEX_BITS,
    parameter int FRAC_W = qdds_pkg::FRAC_BITS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  qdds_pkg::qdds_mode_e       in_mode,
    input  logic [ADDR_W+FRAC_W-1:0]   phase_hi,
    output logic [ADDR_W-1:0]          port_a_addr,
    output logic [ADDR_W-1:0]          port_b_addr,
    output logic [FRAC_W-1:0]          frac,
    output qdds_pkg::qdds_mode_e       mode,
    output logic                       vld
);
    import qdds_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(DEPTH / 4);
    localparam logic [ADDR_W-1:0] NEXT    = ADDR_W'(1);

    typedef struct packed {
        logic              vld;
        qdds_mode_e        mode;
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic [FRAC_W-1:0] frac;
    } addr_state_t;

    addr_state_t ag_d, ag_q;
    logic [ADDR_W-1:0] index;

    always_comb begin
        index       = phase_hi[ADDR_W+FRAC_W-1 -: ADDR_W];
        ag_d        = ag_q;
        ag_d.vld    = in_vld;
        ag_d.mode   = in_mode;
        ag_d.addr_a = index;
        ag_d.frac   = phase_hi[FRAC_W-1:0];
        if (in_mode == MODE_INTERP) begin
            ag_d.addr_b = index + NEXT;
        end else begin
            ag_d.addr_b = index + QUARTER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign port_a_addr = ag_q.addr_a;
    assign port_b_addr = ag_q.addr_b;
    assign frac        = ag_q.frac;
    assign mode        = ag_q.mode;
    assign vld         = ag_q.vld;
endmodule

// File: rtl/qdds_sine_rom.sv
module qdds_sine_rom #(
    parameter int ADDR_W = qdds_pkg::INDEX_BITS,
    parameter int DATA_W = qdds_pkg::SAMPLE_BITS
) (
    input  logic                     clk,
    input  logic [ADDR_W-1:0]        addr_a,
    input  logic [ADDR_W-1:0]        addr_b,
    output logic signed [DATA_W-1:0] data_a,
    output logic signed [DATA_W-1:0] data_b
);
    localparam int  DEPTH  = 1 << ADDR_W;
    localparam real AMPL   = real'((1 << (DATA_W - 1)) - 1);
    localparam real TWO_PI = 6.283185307179586;

    typedef struct packed {
        logic signed [DATA_W-1:0] a;
        logic signed [DATA_W-1:0] b;
    } rd_state_t;

    logic signed [DATA_W-1:0] table_mem [DEPTH];
    rd_state_t rd_d, rd_q;

    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            real v;
            v = AMPL * $sin(TWO_PI * real'(k) / real'(DEPTH));
            if (v >= 0.0) begin
                table_mem[k] = DATA_W'($rtoi(v + 0.5));
            end else begin
                table_mem[k] = DATA_W'(-$rtoi(0.5 - v));
            end
        end
    end

    always_comb begin
        rd_d.a = table_mem[addr_a];
        rd_d.b = table_mem[addr_b];
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign data_a = rd_q.a;
    assign data_b = rd_q.b;
endmodule

// File: rtl/qdds_out_stage.sv
module qdds_out_stage #(
    parameter int DATA_W = qdds_pkg::SAMPLE_BITS,
    parameter int FRAC_W = qdds_pkg::FRAC_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  qdds_pkg::qdds_mode_e     in_mode,
    input  logic [FRAC_W-1:0]        in_frac,
    input  logic signed [DATA_W-1:0] y_lo,
    input  logic signed [DATA_W-1:0] y_hi,
    output logic signed [DATA_W-1:0] sin_smp,
    output logic signed [DATA_W-1:0] cos_smp,
    output logic                     smp_vld,
    output logic                     cos_vld
);
    import qdds_pkg::*;

    localparam int PROD_W = DATA_W + FRAC_W + 2;

    typedef struct packed {
        logic signed [DATA_W-1:0] sin_v;
        logic signed [DATA_W-1:0] cos_v;
        logic                     vld;
        logic                     cvld;
    } out_state_t;

    out_state_t os_d, os_q;
    logic signed [DATA_W:0]   slope;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] step;
    logic signed [PROD_W-1:0] interp;

    always_comb begin
        slope  = (DATA_W+1)'(y_hi) - (DATA_W+1)'(y_lo);
        prod   = PROD_W'(slope) * PROD_W'($signed({1'b0, in_frac}));
        step   = prod >>> FRAC_W;
        interp = PROD_W'(y_lo) + step;

        os_d = '0;
        if (in_vld) begin
            os_d.vld = 1'b1;
            if (in_mode == MODE_INTERP) begin
                os_d.sin_v = DATA_W'(interp);
            end else begin
                os_d.sin_v = y_lo;
                os_d.cos_v = y_hi;
                os_d.cvld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign sin_smp = os_q.sin_v;
    assign cos_smp = os_q.cos_v;
    assign smp_vld = os_q.vld;
    assign cos_vld = os_q.cvld;
endmodule

// File: rtl/qdds_engine.sv
module qdds_engine #(
    parameter int PHASE_W = qdds_pkg::PHASE_BITS,
    parameter int ADDR_W  = qdds_pkg::INDEX_BITS,
    parameter int FRAC_W  = qdds_pkg::FRAC_BITS,
    parameter int DATA_W  = qdds_pkg::SAMPLE_BITS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enable,
    input  logic [PHASE_W-1:0]       tune_word,
    input  logic                     mode_interp,
    output logic signed [DATA_W-1:0] sin_out,
    output logic signed [DATA_W-1:0] cos_out,
    output logic                     out_valid,
    output logic                     cos_valid
);
    import qdds_pkg::*;

    localparam int HI_W = ADDR_W + FRAC_W;

    typedef struct packed {
        logic              vld;
        qdds_mode_e        mode;
        logic [FRAC_W-1:0] frac;
    } side_state_t;

    logic [PHASE_W-1:0] phase_w;
    logic [ADDR_W-1:0]  addr_a_w;
    logic [ADDR_W-1:0]  addr_b_w;
    logic [FRAC_W-1:0]  frac_w;
    qdds_mode_e         mode_w;
    qdds_mode_e         mode_in;
    logic               vld_w;
    logic signed [DATA_W-1:0] ya_w;
    logic signed [DATA_W-1:0] yb_w;
    side_state_t side_d, side_q;

    assign mode_in = mode_interp ? MODE_INTERP : MODE_QUAD;

    qdds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .en    (enable),
        .step  (tune_word),
        .phase (phase_w)
    );

    qdds_addr_gen #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .in_vld      (enable),
        .in_mode     (mode_in),
        .phase_hi    (phase_w[PHASE_W-1 -: HI_W]),
        .port_a_addr (addr_a_w),
        .port_b_addr (addr_b_w),
        .frac        (frac_w),
        .mode        (mode_w),
        .vld         (vld_w)
    );

    qdds_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
        .clk    (clk),
        .addr_a (addr_a_w),
        .addr_b (addr_b_w),
        .data_a (ya_w),
        .data_b (yb_w)
    );

    always_comb begin
        side_d.vld  = vld_w;
        side_d.mode = mode_w;
        side_d.frac = frac_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q <= '0;
        end else begin
            side_q <= side_d;
        end
    end

    qdds_out_stage #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (side_q.vld),
        .in_mode (side_q.mode),
        .in_frac (side_q.frac),
        .y_lo    (ya_w),
        .y_hi    (yb_w),
        .sin_smp (sin_out),
        .cos_smp (cos_out),
        .smp_vld (out_valid),
        .cos_vld (cos_valid)
    );
endmodule

// File: rtl/qdds_engine_chk.sv
module qdds_engine_chk #(
    parameter int PHASE_W = qdds_pkg::PHASE_BITS,
    parameter int DATA_W  = qdds_pkg::SAMPLE_BITS
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     enable,
    input logic [PHASE_W-1:0]       tune_word,
    input logic                     mode_interp,
    input logic signed [DATA_W-1:0] sin_out,
    input logic signed [DATA_W-1:0] cos_out,
    input logic                     out_valid,
    input logic                     cos_valid,
    input logic [PHASE_W-1:0]       phase
);
    localparam longint AMPL = (longint'(1) << (DATA_W - 1)) - 1;
    localparam longint RAD2 = AMPL * AMPL;
    localparam longint TOL  = 2 * AMPL + 4096;

    logic [2:0]   age_q;
    longint       mag2;
    longint       dev;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end

    always_comb begin
        mag2 = longint'(sin_out) * longint'(sin_out) + longint'(cos_out) * longint'(cos_out);
        dev  = (mag2 > RAD2) ? (mag2 - RAD2) : (RAD2 - mag2);
    end

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd1 && $past(enable)) |-> (phase == $past(phase) + $past(tune_word)));

    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd1 && !$past(enable)) |-> (phase == $past(phase)));

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd3) |-> (out_valid == $past(enable, 3)));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (sin_out == '0 && cos_out == '0 && !cos_valid));

    assert_no_cos_interp_R8: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd3 && $past(mode_interp, 3)) |-> (!cos_valid && cos_out == '0));

    assert_cos_present_R6: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 3'd3 && !$past(mode_interp, 3)) |-> (cos_valid == out_valid));

    assert_unit_circle_R6: assert property (@(posedge clk) disable iff (rst)
        cos_valid |-> (dev <= TOL));
endmodule

bind qdds_engine qdds_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .tune_word   (tune_word),
    .mode_interp (mode_interp),
    .sin_out     (sin_out),
    .cos_out     (cos_out),
    .out_valid   (out_valid),
    .cos_valid   (cos_valid),
    .phase       (phase_w)
);

// File: tb/qdds_engine_test.sv
`timescale 1ns/1ps
module qdds_engine_test;

    logic               clk = 1'b0;
    logic               rst;
    logic               enable;
    logic [31:0]        tune_word;
    logic               mode_interp;
    logic signed [15:0] sin_out;
    logic signed [15:0] cos_out;
    logic               out_valid;
    logic               cos_valid;

    int n_checks = 0;
    int n_errors = 0;

    int    tab [1024];
    logic        pv [3];
    logic [31:0] pph [3];
    logic        pm [3];
    logic [31:0] m_phase;

    always #2 clk = ~clk;

    qdds_engine uut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .tune_word   (tune_word),
        .mode_interp (mode_interp),
        .sin_out     (sin_out),
        .cos_out     (cos_out),
        .out_valid   (out_valid),
        .cos_valid   (cos_valid)
    );

    initial begin
        for (int k = 0; k < 1024; k++) begin
            real v;
            v = 32767.0 * $sin(6.283185307179586 * real'(k) / 1024.0);
            tab[k] = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
        end
    end

    // reference model of the requirements: phase history and 3-edge delay
    always @(posedge clk) begin
        if (rst) begin
            m_phase <= '0;
            for (int i = 0; i < 3; i++) begin
                pv[i] <= 1'b0; pph[i] <= '0; pm[i] <= 1'b0;
            end
        end else begin
            pv[0] <= enable; pph[0] <= m_phase; pm[0] <= mode_interp;
            for (int i = 1; i < 3; i++) begin
                pv[i] <= pv[i-1]; pph[i] <= pph[i-1]; pm[i] <= pm[i-1];
            end
            if (enable) m_phase <= m_phase + tune_word;
        end
    end

    function automatic int exp_sin(input logic [31:0] ph, input logic m);
        int n, f, y0, y1, p;
        n = int'(ph[31:22]);
        f = int'(ph[21:10]);
        y0 = tab[n];
        if (!m) return y0;
        y1 = tab[(n + 1) % 1024];
        p = (y1 - y0) * f;
        return y0 + (p >>> 12);
    endfunction

    function automatic int exp_cos(input logic [31:0] ph);
        return tab[(int'(ph[31:22]) + 256) % 1024];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_now(input string req);
        int es, ec;
        bit ev, ecv;
        ev  = pv[2];
        ecv = pv[2] && !pm[2];
        es  = ev  ? exp_sin(pph[2], pm[2]) : 0;
        ec  = ecv ? exp_cos(pph[2]) : 0;
        chk(out_valid == ev, req, "out_valid", int'(out_valid), int'(ev));
        chk(int'(sin_out) == es, req, "sin_out", int'(sin_out), es);
        chk(int'(cos_out) == ec, req, "cos_out", int'(cos_out), ec);
        chk(cos_valid == ecv, req, "cos_valid", int'(cos_valid), int'(ecv));
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_now(req);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; enable = 1'b0; tune_word = '0; mode_interp = 1'b0;
        repeat (3) @(negedge clk);
        chk(!out_valid, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(sin_out == 0 && cos_out == 0, "R1", "sin|cos in reset", int'(sin_out | cos_out), 0);
        chk(!cos_valid, "R1", "cos_valid in reset", int'(cos_valid), 0);
        rst = 1'b0;
        run(4, "R1 R10");
    endtask

    task automatic t_startup(input logic [31:0] tw);
        enable = 1'b1; tune_word = tw; mode_interp = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R3", "valid after edge 1", int'(out_valid), 0);
        @(negedge clk);
        chk(!out_valid, "R3", "valid after edge 2", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid, "R3", "valid after edge 3", int'(out_valid), 1);
        chk(int'(sin_out) == 0, "R4", "first sine", int'(sin_out), 0);
        chk(int'(cos_out) == 32767, "R4", "first cosine", int'(cos_out), 32767);
        chk(cos_valid, "R4", "first cos_valid", int'(cos_valid), 1);
    endtask

    task automatic t_quad();
        mode_interp = 1'b0;
        tune_word = 32'h0040_0000;
        run(1100, "R5 R6");
        tune_word = 32'h0123_4567;
        run(200, "R6 R11");
        tune_word = 32'hFFC0_0000;
        run(60, "R2");
    endtask

    task automatic t_interp();
        mode_interp = 1'b1;
        tune_word = 32'h0005_5555;
        run(300, "R7 R8");
        tune_word = 32'h00C0_0123;
        run(400, "R7 R8");
        chk(!cos_valid && cos_out == 0, "R8", "cos suppressed", int'(cos_out), 0);
    endtask

    task automatic t_tw_change();
        logic [31:0] words [4] = '{32'h0100_0000, 32'h0033_3333, 32'h7654_3210, 32'h0000_1000};
        mode_interp = 1'b0;
        for (int w = 0; w < 4; w++) begin
            tune_word = words[w];
            run(7, "R9");
        end
        mode_interp = 1'b1;
        for (int w = 0; w < 4; w++) begin
            tune_word = words[3 - w];
            run(7, "R9");
        end
    endtask

    task automatic t_mode_toggle();
        tune_word = 32'h0127_9ABC;
        for (int i = 0; i < 12; i++) begin
            mode_interp = ~mode_interp;
            run(i % 3 + 1, "R11 R7");
        end
    endtask

    task automatic t_disable();
        int held;
        mode_interp = 1'b0;
        tune_word = 32'h0250_0000;
        run(5, "R10");
        enable = 1'b0;
        @(negedge clk); chk(out_valid, "R10", "valid edge 1 after disable", int'(out_valid), 1);
        @(negedge clk); chk(out_valid, "R10", "valid edge 2 after disable", int'(out_valid), 1);
        held = tab[int'(m_phase[31:22])];
        @(negedge clk); chk(!out_valid, "R10", "valid edge 3 after disable", int'(out_valid), 0);
        chk(sin_out == 0, "R10", "sine while invalid", int'(sin_out), 0);
        run(10, "R10");
        enable = 1'b1;
        run(3, "R10");
        chk(int'(sin_out) == held, "R10", "resume from held phase", int'(sin_out), held);
        run(20, "R10");
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        @(negedge clk);
        chk(!out_valid && sin_out == 0, "R1", "mid-run reset clears", int'(sin_out), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R1", "first cycle after reset", int'(out_valid), 0);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid && sin_out == 0, "R4", "sine restarts at zero", int'(sin_out), 0);
        chk(int'(cos_out) == 32767, "R4", "cosine restarts full scale", int'(cos_out), 32767);
        run(30, "R2 R6");
    endtask

    initial begin
        #(4 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_startup(32'h0123_4567);
        t_quad();
        t_interp();
        t_tw_change();
        t_mode_toggle();
        t_disable();
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule